// File: doc/BRIEF.md
# Frame-Synchronous Register Commit Engine

This block lets a host stage a batch of display register changes and have them land together at one point in the frame, so timing, plane and cursor settings never change halfway through a scan. The host fills a small update list by index. Each slot names a target register, a mask of bits to preserve and a value to merge in. It then issues a commit. A normal commit waits for the next frame-done event before it replays the list into the register file. A full-modeset commit replays the list at once. Staged cursor position, size and enable ride in the same frame-done slot.

The block also owns the interrupt enable and status bits for the frame-done, vsync and field-start sources. It raises a single interrupt line that stays up until acknowledged. It holds back the flip-completion pulse while a commit is still waiting. In interlaced operation, every field start rewrites the vertical porch, total and vsync-offset registers from the parameter set of the field that is starting.

Top module: `fsync_commit`

## Requirements
- R1: Slots are replayed in index order starting at slot 0. Replay stops at the first slot whose offset is all ones (0xFF), or after the last slot (default depth 17), so slots beyond a terminator are never written. A slot with offset 0xFF is never written.
- R2: Each replayed write stores (old & keep) | value, where old is the register's current content. A keep mask of zero stores the value unchanged.
- R3: A normal commit accepted while idle raises busy_o and sets enable bit 0 (frame-done). No register write happens until a frame-done event arrives while that enable is set.
- R4: On frame-done with enable bit 0 set, a pending list is replayed. Busy then drops after the last write, and enable bit 0 clears itself.
- R5: A full-modeset commit (commit_full_i=1) replays the list without waiting for frame-done, and leaves enable bit 0 untouched.
- R6: A commit requested while busy_o is high is refused and has no effect on the register file or on the pending state.
- R7: A commit made with commit_evt_i=1 produces a one-cycle flip_o pulse in the cycle after a vsync event on which no commit is pending. No pulse is produced while the commit is still pending.
- R8: A cursor write stages position, size and enable and sets enable bit 0. The cursor outputs change only on a frame-done event while enable bit 0 is set.
- R9: Status bits are: bit 0 frame-done, bit 1 vsync, bit 2 field-start. Each is set by its event. Turning on an enable bit whose status bit is already set clears that stale status in the same cycle.
- R10: irq_o rises one cycle after an enabled status bit is set. It then stays high, and no new interrupt is raised, until iack_i. iack_i clears irq_o and all status bits.
- R11: With interlaced_i=1, a field-start event writes three registers in this order, using the set selected by field_odd_i (1 selects index 1): offset 0x10 (vertical porch), offset 0x14 (totals), offset 0x18 (vsync offset). The third write keeps bits 15:12 of the old content and clears those bits from the new value. With interlaced_i=0, nothing is written. A waiting field reload is served before a waiting list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_wr_i | input | 1 | Write one update slot |
| q_idx_i | input | 5 | Slot index |
| q_off_i | input | 8 | Target register offset (0xFF ends the list) |
| q_keep_i | input | 32 | Bits of the old content to keep |
| q_val_i | input | 32 | Value merged into the register |
| commit_i | input | 1 | Commit request |
| commit_full_i | input | 1 | Commit applies immediately (full modeset) |
| commit_evt_i | input | 1 | Commit requests a flip-completion pulse |
| busy_o | output | 1 | A commit is pending or being replayed |
| cur_wr_i | input | 1 | Stage new cursor settings |
| cur_pos_i | input | 32 | Staged cursor position |
| cur_size_i | input | 32 | Staged cursor size |
| cur_on_i | input | 1 | Staged cursor enable |
| cur_pos_o | output | 32 | Live cursor position |
| cur_size_o | output | 32 | Live cursor size |
| cur_on_o | output | 1 | Live cursor enable |
| fdone_i | input | 1 | Frame-done event pulse |
| vsync_i | input | 1 | Vsync event pulse |
| field_i | input | 1 | Field-start event pulse |
| field_odd_i | input | 1 | Field parameter set selector |
| interlaced_i | input | 1 | Interlaced operation |
| fld_vporch_i | input | 2x32 | Vertical porch per field |
| fld_vhtot_i | input | 2x32 | Totals per field |
| fld_vsoff_i | input | 2x32 | Vsync offset per field |
| ien_wr_i | input | 1 | Write interrupt enables |
| ien_i | input | 3 | New interrupt enables |
| iack_i | input | 1 | Interrupt acknowledge |
| ien_o | output | 3 | Current interrupt enables |
| istat_o | output | 3 | Current interrupt status |
| irq_o | output | 1 | Interrupt line |
| flip_o | output | 1 | Flip-completion pulse |
| rf_addr_o | output | 8 | Register file address |
| rf_we_o | output | 1 | Register file write strobe |
| rf_wdata_o | output | 32 | Register file write data |
| rf_rdata_i | input | 32 | Register file read data for the addressed register |

## Verification
The assertions assume that event inputs are single-cycle pulses. They also assume that rf_rdata_i returns the current content of rf_addr_o in the same cycle. Finally, they assume the host does not rewrite the slot being replayed while busy_o is high. The stimulus pulses every event for exactly one cycle and uses a zero-latency register file model. It rewrites slots only after busy_o has dropped. Field-start events are issued only while no list is in flight, so each expected write sequence stays in a known order.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int unsigned OFF_W = 8;
    localparam int unsigned DAT_W = 32;
    localparam int unsigned NSRC  = 3;

    localparam int unsigned SRC_FDONE = 0;
    localparam int unsigned SRC_VSYNC = 1;
    localparam int unsigned SRC_FIELD = 2;

    localparam logic [OFF_W-1:0] OFF_END = '1;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [DAT_W-1:0] keep;
        logic [DAT_W-1:0] val;
    } upd_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_LIST  = 2'd1,
        ENG_FIELD = 2'd2
    } eng_st_t;

    function automatic logic [DAT_W-1:0] merge_word(
        input logic [DAT_W-1:0] old_w,
        input logic [DAT_W-1:0] keep_w,
        input logic [DAT_W-1:0] val_w
    );
        return (old_w & keep_w) | val_w;
    endfunction

endpackage

// File: rtl/fsc_queue.sv
module fsc_queue
    import fsc_pkg::*;
#(
    parameter int unsigned DEPTH = 17,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  upd_t             wr_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output upd_t             rd_ent
);

    localparam upd_t EMPTY_SLOT = '{off: OFF_END, keep: '0, val: '0};

    upd_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        upd_t slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= EMPTY_SLOT;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                slot_q <= wr_ent;
            end
        end
        assign slots[g] = slot_q;
    end

    always_comb begin
        if (rd_idx < IDX_W'(DEPTH)) begin
            rd_ent = slots[rd_idx];
        end else begin
            rd_ent = EMPTY_SLOT;
        end
    end

endmodule

// File: rtl/fsc_irq.sv
module fsc_irq
    import fsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_data,
    input  logic            fd_set,
    input  logic            fd_clr,
    input  logic            ack,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] stat_o,
    output logic            irq_o
);

    logic [NSRC-1:0] en_q, stat_q, en_nx, newly, stat_nx;
    logic            irq_q, armed_q;

    always_comb begin
        en_nx = en_wr ? en_data : en_q;
        if (fd_clr) en_nx[SRC_FDONE] = 1'b0;
        if (fd_set) en_nx[SRC_FDONE] = 1'b1;
        newly   = en_nx & ~en_q;
        stat_nx = ack ? evt : ((stat_q & ~newly) | evt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            stat_q  <= '0;
            irq_q   <= 1'b0;
            armed_q <= 1'b1;
        end else begin
            en_q   <= en_nx;
            stat_q <= stat_nx;
            if (ack) begin
                irq_q   <= 1'b0;
                armed_q <= 1'b1;
            end else if (armed_q && |(stat_q & en_q)) begin
                irq_q   <= 1'b1;
                armed_q <= 1'b0;
            end
        end
    end

    assign en_o   = en_q;
    assign stat_o = stat_q;
    assign irq_o  = irq_q;

    for (genvar b = 0; b < NSRC; b++) begin : g_stale
        // R9
        stale_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (newly[b] && !evt[b] && !ack) |=> !stat_q[b]);
    end

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !ack) |=> irq_q);

    // R10
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !irq_q);

endmodule

// File: rtl/fsc_engine.sv
module fsc_engine
    import fsc_pkg::*;
#(
    parameter int unsigned DEPTH = 17,
    parameter logic [OFF_W-1:0] VPORCH_OFF = 8'h10,
    parameter logic [OFF_W-1:0] VHTOT_OFF  = 8'h14,
    parameter logic [OFF_W-1:0] VSOFF_OFF  = 8'h18,
    parameter logic [DAT_W-1:0] VSOFF_KEEP = 32'h0000_F000,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  list_start,
    input  logic                  fld_start,
    input  logic                  fld_sel,
    input  logic [1:0][DAT_W-1:0] fld_vporch,
    input  logic [1:0][DAT_W-1:0] fld_vhtot,
    input  logic [1:0][DAT_W-1:0] fld_vsoff,
    input  upd_t                  ent,
    input  logic [DAT_W-1:0]      rf_rdata,
    output logic [IDX_W-1:0]      rd_idx,
    output logic                  list_done,
    output logic                  list_busy,
    output logic [OFF_W-1:0]      rf_addr,
    output logic                  rf_we,
    output logic [DAT_W-1:0]      rf_wdata
);

    eng_st_t          st_q;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       fk_q;
    logic             sel_q, sel_pend_q;
    logic             lreq_q, freq_q;
    logic             take_fld, take_list, list_last;
    upd_t             cur;

    assign take_fld  = (st_q == ENG_IDLE) && freq_q;
    assign take_list = (st_q == ENG_IDLE) && !freq_q && lreq_q;
    assign list_last = (st_q == ENG_LIST) &&
                       (ent.off == OFF_END || idx_q == IDX_W'(DEPTH - 1));

    always_comb begin
        cur = '{off: OFF_END, keep: '0, val: '0};
        unique case (st_q)
            ENG_LIST:  cur = ent;
            ENG_FIELD: begin
                unique case (fk_q)
                    2'd0:    cur = '{off: VPORCH_OFF, keep: '0, val: fld_vporch[sel_q]};
                    2'd1:    cur = '{off: VHTOT_OFF,  keep: '0, val: fld_vhtot[sel_q]};
                    default: cur = '{off: VSOFF_OFF,  keep: VSOFF_KEEP,
                                     val: fld_vsoff[sel_q] & ~VSOFF_KEEP};
                endcase
            end
            default: cur = '{off: OFF_END, keep: '0, val: '0};
        endcase
    end

    assign rd_idx    = idx_q;
    assign rf_addr   = cur.off;
    assign rf_we     = ((st_q == ENG_LIST) && ent.off != OFF_END) || (st_q == ENG_FIELD);
    assign rf_wdata  = merge_word(rf_rdata, cur.keep, cur.val);
    assign list_done = list_last;
    assign list_busy = lreq_q || (st_q == ENG_LIST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ENG_IDLE;
            idx_q      <= '0;
            fk_q       <= '0;
            sel_q      <= 1'b0;
            sel_pend_q <= 1'b0;
            lreq_q     <= 1'b0;
            freq_q     <= 1'b0;
        end else begin
            lreq_q <= list_start || (lreq_q && !take_list);
            freq_q <= fld_start  || (freq_q && !take_fld);
            if (fld_start) sel_pend_q <= fld_sel;
            unique case (st_q)
                ENG_IDLE: begin
                    if (take_fld) begin
                        st_q  <= ENG_FIELD;
                        fk_q  <= '0;
                        sel_q <= sel_pend_q;
                    end else if (take_list) begin
                        st_q  <= ENG_LIST;
                        idx_q <= '0;
                    end
                end
                ENG_LIST: begin
                    if (list_last) begin
                        st_q <= ENG_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ENG_FIELD: begin
                    if (fk_q == 2'd2) begin
                        st_q <= ENG_IDLE;
                    end else begin
                        fk_q <= fk_q + 2'd1;
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    // R1
    term_skip_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> rf_addr != OFF_END);

    // R11
    fld_first_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ENG_IDLE && freq_q) |=> st_q == ENG_FIELD);

    // R11
    fld_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ENG_FIELD && fk_q == 2'd0) |=> (st_q == ENG_FIELD && fk_q == 2'd1));

endmodule

// File: rtl/fsync_commit.sv
module fsync_commit
    import fsc_pkg::*;
#(
    parameter int unsigned QDEPTH = 17,
    parameter logic [OFF_W-1:0] VPORCH_OFF = 8'h10,
    parameter logic [OFF_W-1:0] VHTOT_OFF  = 8'h14,
    parameter logic [OFF_W-1:0] VSOFF_OFF  = 8'h18,
    parameter logic [DAT_W-1:0] VSOFF_KEEP = 32'h0000_F000,
    localparam int unsigned IDX_W = $clog2(QDEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  q_wr_i,
    input  logic [IDX_W-1:0]      q_idx_i,
    input  logic [OFF_W-1:0]      q_off_i,
    input  logic [DAT_W-1:0]      q_keep_i,
    input  logic [DAT_W-1:0]      q_val_i,
    input  logic                  commit_i,
    input  logic                  commit_full_i,
    input  logic                  commit_evt_i,
    output logic                  busy_o,
    input  logic                  cur_wr_i,
    input  logic [DAT_W-1:0]      cur_pos_i,
    input  logic [DAT_W-1:0]      cur_size_i,
    input  logic                  cur_on_i,
    output logic [DAT_W-1:0]      cur_pos_o,
    output logic [DAT_W-1:0]      cur_size_o,
    output logic                  cur_on_o,
    input  logic                  fdone_i,
    input  logic                  vsync_i,
    input  logic                  field_i,
    input  logic                  field_odd_i,
    input  logic                  interlaced_i,
    input  logic [1:0][DAT_W-1:0] fld_vporch_i,
    input  logic [1:0][DAT_W-1:0] fld_vhtot_i,
    input  logic [1:0][DAT_W-1:0] fld_vsoff_i,
    input  logic                  ien_wr_i,
    input  logic [NSRC-1:0]       ien_i,
    input  logic                  iack_i,
    output logic [NSRC-1:0]       ien_o,
    output logic [NSRC-1:0]       istat_o,
    output logic                  irq_o,
    output logic                  flip_o,
    output logic [OFF_W-1:0]      rf_addr_o,
    output logic                  rf_we_o,
    output logic [DAT_W-1:0]      rf_wdata_o,
    input  logic [DAT_W-1:0]      rf_rdata_i
);

    upd_t             wr_ent, rd_ent;
    logic [IDX_W-1:0] rd_idx;
    logic             list_done, list_busy, list_start;
    logic             pend_q, flip_wait_q, flip_q;
    logic             accept, fd_serve, fd_set;
    logic [DAT_W-1:0] sh_pos_q, sh_size_q, live_pos_q, live_size_q;
    logic             sh_on_q, live_on_q, cur_pend_q;
    logic [NSRC-1:0]  evt;

    assign wr_ent     = '{off: q_off_i, keep: q_keep_i, val: q_val_i};
    assign busy_o     = pend_q || list_busy;
    assign accept     = commit_i && !busy_o;
    assign fd_serve   = fdone_i && ien_o[SRC_FDONE];
    assign list_start = (accept && commit_full_i) || (fd_serve && pend_q);
    assign fd_set     = (accept && !commit_full_i) || cur_wr_i;

    always_comb begin
        evt            = '0;
        evt[SRC_FDONE] = fdone_i;
        evt[SRC_VSYNC] = vsync_i;
        evt[SRC_FIELD] = field_i;
    end

    fsc_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (q_wr_i),
        .wr_idx (q_idx_i),
        .wr_ent (wr_ent),
        .rd_idx (rd_idx),
        .rd_ent (rd_ent)
    );

    fsc_engine #(
        .DEPTH      (QDEPTH),
        .VPORCH_OFF (VPORCH_OFF),
        .VHTOT_OFF  (VHTOT_OFF),
        .VSOFF_OFF  (VSOFF_OFF),
        .VSOFF_KEEP (VSOFF_KEEP)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .list_start (list_start),
        .fld_start  (field_i && interlaced_i),
        .fld_sel    (field_odd_i),
        .fld_vporch (fld_vporch_i),
        .fld_vhtot  (fld_vhtot_i),
        .fld_vsoff  (fld_vsoff_i),
        .ent        (rd_ent),
        .rf_rdata   (rf_rdata_i),
        .rd_idx     (rd_idx),
        .list_done  (list_done),
        .list_busy  (list_busy),
        .rf_addr    (rf_addr_o),
        .rf_we      (rf_we_o),
        .rf_wdata   (rf_wdata_o)
    );

    fsc_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .en_wr   (ien_wr_i),
        .en_data (ien_i),
        .fd_set  (fd_set),
        .fd_clr  (fd_serve),
        .ack     (iack_i),
        .en_o    (ien_o),
        .stat_o  (istat_o),
        .irq_o   (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            flip_wait_q <= 1'b0;
            flip_q      <= 1'b0;
        end else begin
            if (accept && !commit_full_i) begin
                pend_q <= 1'b1;
            end else if (list_done) begin
                pend_q <= 1'b0;
            end
            flip_q <= 1'b0;
            if (vsync_i && !pend_q && flip_wait_q) begin
                flip_q      <= 1'b1;
                flip_wait_q <= 1'b0;
            end
            if (accept && commit_evt_i) begin
                flip_wait_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_pos_q    <= '0;
            sh_size_q   <= '0;
            sh_on_q     <= 1'b0;
            live_pos_q  <= '0;
            live_size_q <= '0;
            live_on_q   <= 1'b0;
            cur_pend_q  <= 1'b0;
        end else begin
            if (fd_serve && cur_pend_q) begin
                live_pos_q  <= sh_pos_q;
                live_size_q <= sh_size_q;
                live_on_q   <= sh_on_q;
            end
            if (cur_wr_i) begin
                sh_pos_q   <= cur_pos_i;
                sh_size_q  <= cur_size_i;
                sh_on_q    <= cur_on_i;
                cur_pend_q <= 1'b1;
            end else if (fd_serve) begin
                cur_pend_q <= 1'b0;
            end
        end
    end

    assign cur_pos_o  = live_pos_q;
    assign cur_size_o = live_size_q;
    assign cur_on_o   = live_on_q;
    assign flip_o     = flip_q;

    // R3
    commit_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !busy_o && !commit_full_i) |=> (pend_q && ien_o[SRC_FDONE]));

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> $past(list_done));

    // R4
    fd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (fdone_i && ien_o[SRC_FDONE] && !fd_set) |=> !ien_o[SRC_FDONE]);

    // R7
    flip_pend_chk: assert property (@(posedge clk) disable iff (rst)
        flip_o |-> !$past(pend_q));

    // R8
    cur_still_chk: assert property (@(posedge clk) disable iff (rst)
        !fdone_i |=> ($stable(cur_pos_o) && $stable(cur_size_o) && $stable(cur_on_o)));

endmodule

// File: tb/sim_fsync_commit.sv
`timescale 1ns/1ps
module sim_fsync_commit;
    import fsc_pkg::*;

    localparam int IDX_W = 5;
    localparam logic [7:0] A_VP = 8'h10, A_VH = 8'h14, A_VS = 8'h18;
    localparam logic [31:0] KEEP_VS = 32'h0000_F000;

    logic clk = 1'b0, rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             q_wr = 0; logic [IDX_W-1:0] q_idx = 0;
    logic [7:0]       q_off = 0; logic [31:0] q_keep = 0, q_val = 0;
    logic             commit = 0, commit_full = 0, commit_evt = 0, busy;
    logic             cur_wr = 0, cur_on = 0, cur_on_o;
    logic [31:0]      cur_pos = 0, cur_size = 0, cur_pos_o, cur_size_o;
    logic             fdone = 0, vsync = 0, field = 0, field_odd = 0, interlaced = 0;
    logic [1:0][31:0] vporch = '0, vhtot = '0, vsoff = '0;
    logic             ien_wr = 0, iack = 0, irq, flip;
    logic [2:0]       ien = 0, ien_o, istat;
    logic [7:0]       rf_addr; logic rf_we; logic [31:0] rf_wdata, rf_rdata;

    logic [31:0] regmem [256];
    logic [31:0] exp_mem [256];
    logic [7:0]  exp_a [$];
    logic [31:0] exp_d [$];
    string       exp_t [$];
    int n_chk = 0, n_bad = 0, n_wr = 0, n_flip = 0;
    bit  done = 0;

    fsync_commit u0 (
        .clk(clk), .rst(rst),
        .q_wr_i(q_wr), .q_idx_i(q_idx), .q_off_i(q_off), .q_keep_i(q_keep), .q_val_i(q_val),
        .commit_i(commit), .commit_full_i(commit_full), .commit_evt_i(commit_evt), .busy_o(busy),
        .cur_wr_i(cur_wr), .cur_pos_i(cur_pos), .cur_size_i(cur_size), .cur_on_i(cur_on),
        .cur_pos_o(cur_pos_o), .cur_size_o(cur_size_o), .cur_on_o(cur_on_o),
        .fdone_i(fdone), .vsync_i(vsync), .field_i(field), .field_odd_i(field_odd),
        .interlaced_i(interlaced), .fld_vporch_i(vporch), .fld_vhtot_i(vhtot), .fld_vsoff_i(vsoff),
        .ien_wr_i(ien_wr), .ien_i(ien), .iack_i(iack), .ien_o(ien_o), .istat_o(istat),
        .irq_o(irq), .flip_o(flip),
        .rf_addr_o(rf_addr), .rf_we_o(rf_we), .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata)
    );

    assign rf_rdata = regmem[rf_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) regmem[i] <= '0;
        end else if (rf_we) begin
            regmem[rf_addr] <= rf_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    // scoreboard monitor: pops one expected write per observed write
    always @(negedge clk) begin
        if (!rst && rf_we) begin
            n_wr++;
            if (exp_a.size() == 0) begin
                check(1'b0, "R3/R6 unexpected write", {24'h0, rf_addr}, 32'hFFFF_FFFF);
            end else begin
                automatic logic [7:0]  ea = exp_a.pop_front();
                automatic logic [31:0] ed = exp_d.pop_front();
                automatic string       et = exp_t.pop_front();
                check(rf_addr == ea, {et, " addr"}, {24'h0, rf_addr}, {24'h0, ea});
                check(rf_wdata == ed, {et, " data"}, rf_wdata, ed);
            end
        end
        if (!rst && flip) n_flip++;
    end

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic wait_n(input int n); repeat (n) tick(); endtask

    task automatic push_wr(input logic [7:0] a, input logic [31:0] k, input logic [31:0] v, input string t);
        logic [31:0] d;
        d = (exp_mem[a] & k) | v;
        exp_mem[a] = d;
        exp_a.push_back(a); exp_d.push_back(d); exp_t.push_back(t);
    endtask

    task automatic qwr(input int i, input logic [7:0] o, input logic [31:0] k, input logic [31:0] v);
        q_wr = 1; q_idx = IDX_W'(i); q_off = o; q_keep = k; q_val = v;
        tick(); q_wr = 0;
    endtask

    task automatic do_commit(input bit full, input bit ev);
        commit = 1; commit_full = full; commit_evt = ev;
        tick(); commit = 0; commit_full = 0; commit_evt = 0;
    endtask

    task automatic pulse_fdone(); fdone = 1; tick(); fdone = 0; endtask
    task automatic pulse_vsync(); vsync = 1; tick(); vsync = 0; endtask
    task automatic pulse_field(); field = 1; tick(); field = 0; endtask
    task automatic pulse_ack(); iack = 1; tick(); iack = 0; endtask
    task automatic set_ien(input logic [2:0] v); ien_wr = 1; ien = v; tick(); ien_wr = 0; endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R4 act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w0, f0;
        for (int i = 0; i < 256; i++) exp_mem[i] = '0;
        wait_n(4); rst = 0; tick();

        // reset state
        check(busy == 0, "R3 reset busy", {31'h0, busy}, 0);
        check(irq == 0, "R10 reset irq", {31'h0, irq}, 0);
        check(ien_o == 0 && istat == 0, "R9 reset en/stat", {26'h0, ien_o, istat}, 0);
        check(cur_on_o == 0, "R8 reset cursor", {31'h0, cur_on_o}, 0);

        // R5: modeset applies at once, preload 0x21
        qwr(0, 8'h21, 0, 32'hABCD_5555); qwr(1, 8'hFF, 0, 0);
        push_wr(8'h21, 0, 32'hABCD_5555, "R5");
        do_commit(1, 0); wait_n(8);
        check(exp_a.size() == 0, "R5 immediate replay", exp_a.size(), 0);
        check(ien_o[0] == 0, "R5 enable untouched", {31'h0, ien_o[0]}, 0);

        // R3/R4/R2/R1/R7: normal commit waits for frame-done
        qwr(0, 8'h20, 0, 32'hA5A5_0001);
        qwr(1, 8'h21, 32'hFFFF_0000, 32'h0000_1234);
        qwr(2, 8'hFF, 0, 0);
        qwr(3, 8'h22, 0, 32'h0000_DEAD);
        f0 = n_flip;
        do_commit(0, 1);
        check(busy == 1, "R3 busy after commit", {31'h0, busy}, 1);
        check(ien_o[0] == 1, "R3 frame-done enable", {31'h0, ien_o[0]}, 1);
        wait_n(8);
        pulse_vsync(); wait_n(3);
        check(n_flip == f0, "R7 no flip while pending", n_flip, f0);
        push_wr(8'h20, 0, 32'hA5A5_0001, "R4");
        push_wr(8'h21, 32'hFFFF_0000, 32'h0000_1234, "R2");
        pulse_fdone(); wait_n(8);
        check(exp_a.size() == 0, "R4 replay done", exp_a.size(), 0);
        check(busy == 0, "R4 busy clears", {31'h0, busy}, 0);
        check(ien_o[0] == 0, "R4 enable self-clears", {31'h0, ien_o[0]}, 0);
        check(regmem[8'h21] == 32'hABCD_1234, "R2 masked merge", regmem[8'h21], 32'hABCD_1234);
        check(regmem[8'h22] == 0, "R1 past terminator", regmem[8'h22], 0);
        pulse_vsync(); wait_n(2);
        check(n_flip == f0 + 1, "R7 flip after commit", n_flip, f0 + 1);

        // R6: commit while busy refused
        qwr(0, 8'h30, 0, 32'h0000_0011); qwr(1, 8'hFF, 0, 0);
        do_commit(0, 0);
        w0 = n_wr;
        do_commit(1, 0); wait_n(8);
        check(n_wr == w0, "R6 refused no writes", n_wr, w0);
        check(busy == 1, "R6 still pending", {31'h0, busy}, 1);
        push_wr(8'h30, 0, 32'h0000_0011, "R4");
        pulse_fdone(); wait_n(8);
        check(exp_a.size() == 0 && busy == 0, "R4 second replay", exp_a.size(), 0);

        // R1: full depth, no terminator
        for (int i = 0; i < 17; i++) qwr(i, 8'h40 + 8'(i), 0, 32'h100 + 32'(i));
        for (int i = 0; i < 17; i++) push_wr(8'h40 + 8'(i), 0, 32'h100 + 32'(i), "R1");
        w0 = n_wr;
        do_commit(1, 0); wait_n(30);
        check(n_wr == w0 + 17, "R1 full depth count", n_wr, w0 + 17);
        check(exp_a.size() == 0, "R1 full depth order", exp_a.size(), 0);

        // R8: cursor staged then applied at frame-done
        cur_wr = 1; cur_pos = 32'h0010_0020; cur_size = 32'h0020_0040; cur_on = 1;
        tick(); cur_wr = 0;
        check(cur_on_o == 0 && cur_pos_o == 0, "R8 cursor held", cur_pos_o, 0);
        check(ien_o[0] == 1, "R8 cursor enables frame-done", {31'h0, ien_o[0]}, 1);
        wait_n(3);
        pulse_fdone();
        check(cur_pos_o == 32'h0010_0020, "R8 cursor pos", cur_pos_o, 32'h0010_0020);
        check(cur_size_o == 32'h0020_0040 && cur_on_o == 1, "R8 cursor size/on", cur_size_o, 32'h0020_0040);

        // R9/R10: stale status and interrupt hold
        pulse_ack(); tick();
        check(irq == 0 && istat == 0, "R10 ack clears", {28'h0, irq, istat}, 0);
        set_ien(3'b000);
        pulse_field();
        check(istat[2] == 1, "R9 status sets while disabled", {31'h0, istat[2]}, 1);
        set_ien(3'b100);
        check(istat[2] == 0, "R9 stale status cleared", {31'h0, istat[2]}, 0);
        wait_n(2);
        check(irq == 0, "R10 no irq from stale", {31'h0, irq}, 0);
        set_ien(3'b010);
        pulse_vsync(); tick();
        check(irq == 1, "R10 irq raised", {31'h0, irq}, 1);
        pulse_vsync(); wait_n(3);
        check(irq == 1, "R10 irq held until ack", {31'h0, irq}, 1);
        pulse_ack();
        check(irq == 0 && istat == 0, "R10 ack drops irq", {28'h0, irq, istat}, 0);
        pulse_vsync(); tick();
        check(irq == 1, "R10 re-armed by ack", {31'h0, irq}, 1);
        pulse_ack();

        // R11: interlaced field reload
        qwr(0, A_VS, 0, 32'hFFFF_FFFF); qwr(1, 8'hFF, 0, 0);
        push_wr(A_VS, 0, 32'hFFFF_FFFF, "R5");
        do_commit(1, 0); wait_n(8);
        vporch[1] = 32'h0016_0002; vhtot[1] = 32'h0232_0A50; vsoff[1] = 32'h0990_0990;
        vporch[0] = 32'h0015_0001; vhtot[0] = 32'h0233_0A50; vsoff[0] = 32'h0468_0468;
        interlaced = 1; field_odd = 1;
        push_wr(A_VP, 0, vporch[1], "R11");
        push_wr(A_VH, 0, vhtot[1], "R11");
        push_wr(A_VS, KEEP_VS, vsoff[1] & ~KEEP_VS, "R11");
        pulse_field(); wait_n(8);
        check(exp_a.size() == 0, "R11 odd field reload", exp_a.size(), 0);
        check(regmem[A_VS] == 32'h0990_F990, "R11 vsync keep bits", regmem[A_VS], 32'h0990_F990);
        field_odd = 0;
        push_wr(A_VP, 0, vporch[0], "R11");
        push_wr(A_VH, 0, vhtot[0], "R11");
        push_wr(A_VS, KEEP_VS, vsoff[0] & ~KEEP_VS, "R11");
        pulse_field(); wait_n(8);
        check(exp_a.size() == 0, "R11 even field reload", exp_a.size(), 0);
        interlaced = 0;
        w0 = n_wr;
        pulse_field(); wait_n(8);
        check(n_wr == w0, "R11 progressive no reload", n_wr, w0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule